// File: doc/BRIEF.md
# USB Device Mode and Address Control Register

This block is the command-driven control register file of a full-speed USB peripheral controller. A local processor presents a command code with `cmd_valid`, and the block either stores the low byte of `wr_data` into the mode register or the address register, or returns one of them on `rd_data` with `rd_valid`. Every command is one transaction that moves one byte. The command port has no back-pressure. A command is taken in every cycle that `cmd_valid` is high, so there is no ready signal. A read answers exactly one cycle later.

The stored bits drive plain control outputs:
- the DMA width select;
- the device enable and the 7-bit device address;
- the pull-up enable, which is masked when an external pull-up is strapped in;
- a one-cycle suspend request.

Endpoint events arrive as single-cycle pulses. The block passes them to a registered interrupt output. Which events pass depends on the debug bit, and all of them are gated by the interrupt enable bit. A USB bus reset clears the address register and leaves the mode bits untouched.

Top module: `usb_mode_ctrl`

## Requirements
- R1: Command code 0xB8 writes the mode register and 0xB9 reads it. A read drives `rd_valid` high for one cycle, one clock after the command, with the register value in `rd_data`.
- R2: Only `wr_data[7:0]` is stored. The upper byte of `wr_data` is ignored. `rd_data[15:8]` always reads 0.
- R3: Mode register bit positions: 7 is DMA width, 5 is suspend trigger, 3 is interrupt enable, 2 is debug and 0 is pull-up enable. Bits 6, 4 and 1 discard writes and read as 0, so a mode read equals the written byte ANDed with 0xAD.
- R4: `dma_wide` equals mode bit 7 (1 selects 16-bit DMA, 0 selects 8-bit DMA) from the cycle after the write.
- R5: `suspend_req` pulses high for exactly one cycle, in the cycle after a mode write that clears bit 5 while the stored bit 5 is 1. Any other mode write, including a repeated write of 1 or of 0, gives no pulse.
- R6: While mode bit 3 is 0, `irq` stays low for every event input.
- R7: `irq` is high in the cycle after an event that bit 2 selects. With bit 2 at 1, `ev_nak` or `ev_err` selects. With bit 2 at 0, `ev_bulk_ack` or `ev_iso_done` selects. Events that are not selected give no interrupt.
- R8: `pullup_en` equals mode bit 0 when `ext_pullup` is 0. It is 0 whenever `ext_pullup` is 1.
- R9: A `usb_bus_reset` pulse leaves every mode bit unchanged. It clears the address register to 0 and takes priority over an address write in the same cycle.
- R10: Code 0xD0 writes the address register and 0xD1 reads it. Bit 7 drives `dev_enable` and bits 6..0 drive `dev_addr`.
- R11: `rst_n` low clears both registers, the suspend trigger history, `irq`, `suspend_req`, `rd_valid` and `rd_data`.
- R12: A command with any other code changes no register and gives no `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_code | input | 8 | Command code |
| wr_data | input | 16 | Write data, only the low byte is used |
| rd_valid | output | 1 | Read data valid, one cycle |
| rd_data | output | 16 | Read data, upper byte zero |
| ext_pullup | input | 1 | External pull-up strap, masks pull-up enable |
| usb_bus_reset | input | 1 | USB bus reset pulse |
| ev_nak | input | 1 | NAK event pulse |
| ev_err | input | 1 | Error event pulse |
| ev_bulk_ack | input | 1 | Bulk ACK event pulse |
| ev_iso_done | input | 1 | Isochronous transfer done pulse |
| dma_wide | output | 1 | 16-bit DMA width select |
| dev_enable | output | 1 | Device enable |
| dev_addr | output | 7 | USB device address |
| pullup_en | output | 1 | Bus pull-up enable |
| suspend_req | output | 1 | Suspend request pulse |
| irq | output | 1 | Qualified interrupt pulse |

## Verification
A corrupted mode bit shows on `dma_wide` or `pullup_en` in the very next cycle, and a mode read returns it one cycle after the read command. A lost or stuck suspend trigger history appears as a missing or extra `suspend_req` pulse on the first write that clears bit 5. A wrong debug or enable bit shows up on the first event pulse as an `irq` that comes when none is expected, or that does not come. State lost in a bus reset shows on the next register read-back.

// File: rtl/usb_mode_pkg.sv
package usb_mode_pkg;
  localparam int BYTE_W = 8;
  localparam logic [7:0] CMD_MODE_WR = 8'hB8;
  localparam logic [7:0] CMD_MODE_RD = 8'hB9;
  localparam logic [7:0] CMD_ADDR_WR = 8'hD0;
  localparam logic [7:0] CMD_ADDR_RD = 8'hD1;
  localparam int BIT_DMAW = 7;
  localparam int BIT_SUSP = 5;
  localparam int BIT_INTE = 3;
  localparam int BIT_DBG  = 2;
  localparam int BIT_SOFT = 0;
  localparam logic [7:0] MODE_MASK = 8'hAD;
  typedef enum logic [2:0] {
    OP_NONE, OP_MODE_WR, OP_MODE_RD, OP_ADDR_WR, OP_ADDR_RD
  } op_e;
endpackage

// File: rtl/usb_cmd_decode.sv
module usb_cmd_decode
  import usb_mode_pkg::*;
(
  input  logic       cmd_valid,
  input  logic [7:0] cmd_code,
  output op_e        op
);
  always_comb begin
    op = OP_NONE;
    if (cmd_valid) begin
      unique case (cmd_code)
        CMD_MODE_WR: op = OP_MODE_WR;
        CMD_MODE_RD: op = OP_MODE_RD;
        CMD_ADDR_WR: op = OP_ADDR_WR;
        CMD_ADDR_RD: op = OP_ADDR_RD;
        default:     op = OP_NONE;
      endcase
    end
  end
endmodule

// File: rtl/usb_mode_regs.sv
module usb_mode_regs
  import usb_mode_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_byte,
  output logic [BYTE_W-1:0] mode_q,
  output logic              suspend_req
);
  logic [BYTE_W-1:0] mode_next;
  assign mode_next = wr_byte & MODE_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q      <= '0;
      suspend_req <= 1'b0;
    end else begin
      suspend_req <= wr_en && mode_q[BIT_SUSP] && !mode_next[BIT_SUSP];
      if (wr_en) mode_q <= mode_next;
    end
  end

  p_susp_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    suspend_req |=> !suspend_req);
  p_susp_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    suspend_req |-> (!mode_q[BIT_SUSP] && $past(mode_q[BIT_SUSP])));
  p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mode_q));
endmodule

// File: rtl/usb_addr_reg.sv
module usb_addr_reg
  import usb_mode_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              bus_rst,
  input  logic [BYTE_W-1:0] wr_byte,
  output logic [BYTE_W-1:0] addr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (bus_rst) addr_q <= '0;
    else if (wr_en)   addr_q <= wr_byte;
  end

  p_busrst_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> (addr_q == '0));
endmodule

// File: rtl/usb_irq_qual.sv
module usb_irq_qual (
  input  logic clk,
  input  logic rst_n,
  input  logic intena,
  input  logic dbg,
  input  logic ev_nak,
  input  logic ev_err,
  input  logic ev_bulk_ack,
  input  logic ev_iso_done,
  output logic irq
);
  logic dbg_hit, norm_hit;
  assign dbg_hit  = ev_nak | ev_err;
  assign norm_hit = ev_bulk_ack | ev_iso_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= intena && (dbg ? dbg_hit : norm_hit);
  end

  p_irq_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(intena));
  p_irq_dbg_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && $past(dbg)) |-> $past(ev_nak || ev_err));
  p_irq_norm_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !$past(dbg)) |-> $past(ev_bulk_ack || ev_iso_done));
endmodule

// File: rtl/usb_mode_ctrl.sv
module usb_mode_ctrl
  import usb_mode_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_code,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ext_pullup,
  input  logic              usb_bus_reset,
  input  logic              ev_nak,
  input  logic              ev_err,
  input  logic              ev_bulk_ack,
  input  logic              ev_iso_done,
  output logic              dma_wide,
  output logic              dev_enable,
  output logic [ADDR_W-1:0] dev_addr,
  output logic              pullup_en,
  output logic              suspend_req,
  output logic              irq
);
  localparam int PAD_W = DATA_W - BYTE_W;

  op_e               op;
  logic [BYTE_W-1:0] wr_byte, mode_q, addr_q, rd_byte;

  assign wr_byte = wr_data[BYTE_W-1:0];

  usb_cmd_decode u_dec (.cmd_valid(cmd_valid), .cmd_code(cmd_code), .op(op));

  usb_mode_regs u_mode (
    .clk(clk), .rst_n(rst_n), .wr_en(op == OP_MODE_WR), .wr_byte(wr_byte),
    .mode_q(mode_q), .suspend_req(suspend_req)
  );

  usb_addr_reg u_addr (
    .clk(clk), .rst_n(rst_n), .wr_en(op == OP_ADDR_WR), .bus_rst(usb_bus_reset),
    .wr_byte(wr_byte), .addr_q(addr_q)
  );

  usb_irq_qual u_irq (
    .clk(clk), .rst_n(rst_n), .intena(mode_q[BIT_INTE]), .dbg(mode_q[BIT_DBG]),
    .ev_nak(ev_nak), .ev_err(ev_err), .ev_bulk_ack(ev_bulk_ack),
    .ev_iso_done(ev_iso_done), .irq(irq)
  );

  assign dma_wide   = mode_q[BIT_DMAW];
  assign pullup_en  = mode_q[BIT_SOFT] & ~ext_pullup;
  assign dev_enable = addr_q[BYTE_W-1];
  assign dev_addr   = addr_q[ADDR_W-1:0];
  assign rd_byte    = (op == OP_ADDR_RD) ? addr_q : mode_q;

  generate
    if (PAD_W > 0) begin : g_wide
      logic unused_hi;
      assign unused_hi = ^wr_data[DATA_W-1:BYTE_W];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_data <= '0;
        else if (op == OP_MODE_RD || op == OP_ADDR_RD)
          rd_data <= {{PAD_W{1'b0}}, rd_byte};
      end
      p_rd_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_data[DATA_W-1:BYTE_W] == '0));
    end else begin : g_narrow
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_data <= '0;
        else if (op == OP_MODE_RD || op == OP_ADDR_RD) rd_data <= rd_byte;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= (op == OP_MODE_RD) || (op == OP_ADDR_RD);
  end

  p_rd_resp_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(cmd_valid && (cmd_code == CMD_MODE_RD || cmd_code == CMD_ADDR_RD)));
  p_pullup_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ext_pullup |-> !pullup_en);
endmodule

// File: tb/usb_mode_ctrl_tb.sv
module usb_mode_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        cmd_valid = 0, ext_pullup = 0, usb_bus_reset = 0;
  logic        ev_nak = 0, ev_err = 0, ev_bulk_ack = 0, ev_iso_done = 0;
  logic [7:0]  cmd_code = 0;
  logic [15:0] wr_data = 0;
  logic        rd_valid, dma_wide, dev_enable, pullup_en, suspend_req, irq;
  logic [15:0] rd_data;
  logic [6:0]  dev_addr;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_mode_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .wr_data(wr_data), .rd_valid(rd_valid), .rd_data(rd_data),
    .ext_pullup(ext_pullup), .usb_bus_reset(usb_bus_reset),
    .ev_nak(ev_nak), .ev_err(ev_err), .ev_bulk_ack(ev_bulk_ack),
    .ev_iso_done(ev_iso_done), .dma_wide(dma_wide), .dev_enable(dev_enable),
    .dev_addr(dev_addr), .pullup_en(pullup_en), .suspend_req(suspend_req),
    .irq(irq)
  );

  // write data, expected read-back, expected dma_wide, expected suspend pulse
  localparam int NV = 6;
  localparam logic [25:0] VEC [NV] = '{
    {16'hFFFF, 8'hAD, 1'b1, 1'b0},
    {16'h5200, 8'h00, 1'b0, 1'b1},
    {16'h12A5, 8'hA5, 1'b1, 1'b0},
    {16'hAB52, 8'h00, 1'b0, 1'b1},
    {16'h0F0C, 8'h0C, 1'b0, 1'b0},
    {16'h3381, 8'h81, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one command for one cycle; returns at the negedge after the edge
  task automatic cmd(input logic [7:0] c, input logic [15:0] d);
    @(negedge clk); cmd_valid = 1; cmd_code = c; wr_data = d;
    @(negedge clk); cmd_valid = 0; cmd_code = 8'h00; wr_data = 16'h0;
  endtask

  task automatic ev(input logic n, input logic e, input logic a, input logic i);
    @(negedge clk); ev_nak = n; ev_err = e; ev_bulk_ack = a; ev_iso_done = i;
    @(negedge clk); ev_nak = 0; ev_err = 0; ev_bulk_ack = 0; ev_iso_done = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 dma_wide", dma_wide, 0);
    chk("R11 dev_enable", dev_enable, 0);
    chk("R11 irq", irq, 0);
    chk("R11 rd_valid", rd_valid, 0);
    rst_n = 1;
    cmd(8'hB9, 0);
    chk("R11 mode after reset", rd_data, 0);

    // table walk: R1 R2 R3 R4 R5
    for (int k = 0; k < NV; k++) begin
      cmd(8'hB8, VEC[k][25:10]);
      chk("R4 dma_wide", dma_wide, VEC[k][1]);
      chk("R5 suspend pulse", suspend_req, VEC[k][0]);
      cmd(8'hB9, 16'hFFFF);
      chk("R1 rd_valid", rd_valid, 1);
      chk("R3 mode readback", rd_data, {8'h00, VEC[k][9:2]});
      @(negedge clk);
      chk("R1 rd_valid one cycle", rd_valid, 0);
      chk("R5 pulse one cycle", suspend_req, 0);
    end

    // R5 repeated writes of 1 and of 0
    cmd(8'hB8, 16'h0000);
    cmd(8'hB8, 16'h0020); chk("R5 set no pulse", suspend_req, 0);
    cmd(8'hB8, 16'h0020); chk("R5 reset-1 no pulse", suspend_req, 0);
    cmd(8'hB8, 16'h0000); chk("R5 clear pulse", suspend_req, 1);
    @(negedge clk);        chk("R5 pulse drops", suspend_req, 0);
    cmd(8'hB8, 16'h0000); chk("R5 second clear no pulse", suspend_req, 0);

    // R6 gating, R7 source selection
    cmd(8'hB8, 16'h0000);
    ev(1, 1, 1, 1); chk("R6 irq gated", irq, 0);
    cmd(8'hB8, 16'h0008);
    ev(0, 0, 1, 0); chk("R7 normal ack", irq, 1);
    ev(0, 0, 0, 1); chk("R7 normal iso", irq, 1);
    ev(1, 1, 0, 0); chk("R7 normal ignores nak/err", irq, 0);
    cmd(8'hB8, 16'h000C);
    ev(1, 0, 0, 0); chk("R7 debug nak", irq, 1);
    ev(0, 1, 0, 0); chk("R7 debug err", irq, 1);
    ev(0, 0, 1, 1); chk("R7 debug ignores ack/iso", irq, 0);
    cmd(8'hB8, 16'h0004);
    ev(1, 1, 0, 0); chk("R6 debug gated", irq, 0);

    // R8 pull-up masking
    cmd(8'hB8, 16'h0001);
    chk("R8 pullup on", pullup_en, 1);
    ext_pullup = 1; #1;
    chk("R8 pullup masked", pullup_en, 0);
    ext_pullup = 0;

    // R10 address register
    cmd(8'hD0, 16'hFFC3);
    chk("R10 dev_enable", dev_enable, 1);
    chk("R10 dev_addr", dev_addr, 7'h43);
    cmd(8'hD1, 0);
    chk("R10 addr readback", rd_data, 16'h00C3);

    // R9 bus reset
    cmd(8'hB8, 16'h00AD);
    @(negedge clk); usb_bus_reset = 1; cmd_valid = 1; cmd_code = 8'hD0; wr_data = 16'h0085;
    @(negedge clk); usb_bus_reset = 0; cmd_valid = 0;
    chk("R9 addr cleared", dev_enable, 0);
    cmd(8'hB9, 0); chk("R9 mode kept", rd_data, 16'h00AD);
    cmd(8'hD1, 0); chk("R9 addr reads zero", rd_data, 16'h0000);

    // R12 unknown code
    cmd(8'h55, 16'h0000);
    chk("R12 no rd_valid", rd_valid, 0);
    chk("R12 dma_wide kept", dma_wide, 1);
    cmd(8'hB9, 0); chk("R12 mode unchanged", rd_data, 16'h00AD);

    // R11 mid-run reset
    cmd(8'hD0, 16'h0081);
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    chk("R11 dma cleared", dma_wide, 0);
    chk("R11 addr cleared", dev_enable, 0);
    rst_n = 1;
    cmd(8'hB8, 16'h0000); chk("R11 suspend history cleared", suspend_req, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule